// File: doc/BRIEF.md
# RTC Alarm and Periodic Interrupt Flag Controller

This block keeps the sticky interrupt flags of a real-time clock and drives its two active-low interrupt pins. It serves two alarm channels, a weekly one and a daily one, plus one periodic interrupt source. The time comparators sit outside the block and report a match as a one-cycle pulse. The 32.768 kHz timebase arrives as a one-cycle tick strobe in the block's clock domain.

An alarm match does not set its flag at once. The flag is set a fixed number of timing ticks later, which gives a delay of about 61 µs at the default of two ticks. Software clears a flag by writing 0 to its bit. Writing 1 does nothing. An alarm flag reads as 0 while its enable is off, and its pin stays released until a later match. The periodic flag has two modes. In level mode it is held until software clears it. In pulse mode it clears itself on the next timing tick.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: While reset is asserted, all three flags read 0 and both interrupt pins are high.
- R2: Timing ticks are counted only in the cycles after the match cycle. An alarm flag becomes 1 in the cycle after the clock edge that samples the DELAY_TICKS-th such tick.
- R3: While an alarm's enable is 0, that flag reads 0, its pin contribution is released, matches are ignored, and any stored flag or pending match is discarded.
- R4: Flag bit positions in wr_data_i and flags_o are: bit 0 weekly, bit 1 daily, bit 2 periodic. Writing 0 to an alarm bit clears that flag on the next edge. Writing 1 to any bit has no effect.
- R5: Once an alarm flag has been cleared, its pin stays high, over any number of timing ticks, until a new match sets the flag again.
- R6: If a match pulse arrives in the same cycle as a write of 0 to that alarm's flag, the write wins and the match is discarded.
- R7: intrb_no is low exactly when the weekly flag reads 1. intra_no is low when the daily flag or the periodic flag reads 1.
- R8: In level mode (level_mode_i = 1), per_tick_i sets the periodic flag. The flag then holds until a write of 0 to bit 2 clears it.
- R9: In pulse mode (level_mode_i = 0), the periodic flag clears itself on the first timing tick after the cycle that set it, and writes to bit 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick32k_i | input | 1 | One-cycle strobe per 32.768 kHz period |
| alm_match_i | input | 2 | Alarm match pulses, bit 0 weekly, bit 1 daily |
| alm_en_i | input | 2 | Alarm enables, bit 0 weekly, bit 1 daily |
| per_tick_i | input | 1 | Periodic interrupt event pulse |
| level_mode_i | input | 1 | 1: periodic flag held, 0: self-clearing pulse |
| wr_en_i | input | 1 | Flag register write strobe |
| wr_data_i | input | 3 | Flag write data; a 0 bit clears that flag |
| flags_o | output | 3 | Flag readback, masked by the alarm enables |
| intra_no | output | 1 | Daily-alarm or periodic interrupt, active low |
| intrb_no | output | 1 | Weekly-alarm interrupt, active low |

## Verification
The bench builds the block with DELAY_TICKS = 3 rather than the default of 2. With three ticks, a check after the second tick catches a counter that fires early, and a check after the third tick catches one that fires late. The bench drives every tick by hand, so the cycle in which a flag must appear follows directly from the stimulus. This makes it possible to test the collision between a match and a clear, the enable-off discard, and the self-clear in pulse mode, each on an exact edge.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_ALARMS = 2;
  localparam int NUM_FLAGS  = 3;
  localparam int FLAG_WEEK  = 0;
  localparam int FLAG_DAY   = 1;
  localparam int FLAG_PER   = 2;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/rtc_alarm_chan.sv
module rtc_alarm_chan #(
  parameter int DELAY_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic match_i,
  input  logic en_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (!en_i) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (clr_i) flag_q <= 1'b0;
      if (match_i && !clr_i) begin
        // a new match restarts the delay window
        pend_q <= 1'b1;
        cnt_q  <= '0;
      end else if (pend_q && tick_i) begin
        if (cnt_q == LAST) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
          if (!clr_i) flag_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign flag_o = flag_q & en_i;
endmodule

// File: rtl/rtc_periodic_flag.sv
module rtc_periodic_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic per_tick_i,
  input  logic level_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (level_i) begin
      if (clr_i)           flag_q <= 1'b0;
      else if (per_tick_i) flag_q <= 1'b1;
    end else begin
      if (per_tick_i)      flag_q <= 1'b1;
      else if (tick_i)     flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_irq_pins.sv
module rtc_irq_pins
  import rtc_irq_pkg::*;
(
  input  flag_vec_t flags_i,
  output logic      intra_no,
  output logic      intrb_no
);
  assign intrb_no = ~flags_i[FLAG_WEEK];
  assign intra_no = ~(flags_i[FLAG_DAY] | flags_i[FLAG_PER]);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int DELAY_TICKS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick32k_i,
  input  logic [NUM_ALARMS-1:0] alm_match_i,
  input  logic [NUM_ALARMS-1:0] alm_en_i,
  input  logic                  per_tick_i,
  input  logic                  level_mode_i,
  input  logic                  wr_en_i,
  input  logic [NUM_FLAGS-1:0]  wr_data_i,
  output logic [NUM_FLAGS-1:0]  flags_o,
  output logic                  intra_no,
  output logic                  intrb_no
);
  flag_vec_t flags;
  flag_vec_t clr;

  // only a written 0 clears
  assign clr = {NUM_FLAGS{wr_en_i}} & ~wr_data_i;

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alm
    rtc_alarm_chan #(.DELAY_TICKS(DELAY_TICKS)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick32k_i),
      .match_i (alm_match_i[g]),
      .en_i    (alm_en_i[g]),
      .clr_i   (clr[g]),
      .flag_o  (flags[g])
    );
  end

  rtc_periodic_flag u_per (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick32k_i),
    .per_tick_i (per_tick_i),
    .level_i    (level_mode_i),
    .clr_i      (clr[FLAG_PER]),
    .flag_o     (flags[FLAG_PER])
  );

  rtc_irq_pins u_pins (
    .flags_i  (flags),
    .intra_no (intra_no),
    .intrb_no (intrb_no)
  );

  assign flags_o = flags;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick32k_i,
  input logic [1:0] alm_match_i,
  input logic [1:0] alm_en_i,
  input logic       per_tick_i,
  input logic       level_mode_i,
  input logic       wr_en_i,
  input logic [2:0] wr_data_i,
  input logic [2:0] flags_o,
  input logic       intra_no,
  input logic       intrb_no
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (flags_o == 3'b000 && intra_no && intrb_no));

  // R2
  week_set_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[0]) |-> $past(tick32k_i));

  // R3
  week_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alm_en_i[0] |-> !flags_o[0]);

  // R3
  day_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alm_en_i[1] |-> !flags_o[1]);

  // R4
  week_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[0]) |=> !flags_o[0]);

  // R7
  pin_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intrb_no == !flags_o[0]);

  // R7
  pin_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intra_no == !(flags_o[1] || flags_o[2]));

  // R8
  per_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[2]) |-> $past(per_tick_i));

  // R9
  per_pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_mode_i && flags_o[2] && tick32k_i && !per_tick_i) |=> !flags_o[2]);
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (.*);

// File: tb/rtc_irq_ctrl_bench.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_bench;
  localparam int DLY = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick32k_i, per_tick_i, level_mode_i, wr_en_i;
  logic [1:0] alm_match_i, alm_en_i;
  logic [2:0] wr_data_i, flags_o;
  logic       intra_no, intrb_no;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    string      tag;
    logic [2:0] f;
    logic       a;
    logic       b;
  } exp_t;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  rtc_irq_ctrl #(.DELAY_TICKS(DLY)) u_rtc_irq_ctrl (.*);

  logic [1:0] en_q  = 2'b11;
  logic       lvl_q = 1'b1;

  task automatic step(input logic [1:0] m, input logic t, input logic p,
                      input logic we, input logic [2:0] wd);
    @(negedge clk_i);
    alm_match_i = m; tick32k_i = t; per_tick_i = p;
    wr_en_i = we; wr_data_i = wd; alm_en_i = en_q; level_mode_i = lvl_q;
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();   step(2'b00, 1'b0, 1'b0, 1'b0, 3'b111); endtask
  task automatic tick();   step(2'b00, 1'b1, 1'b0, 1'b0, 3'b111); endtask
  task automatic wr(input logic [2:0] d); step(2'b00, 1'b0, 1'b0, 1'b1, d); endtask

  task automatic expect_out(input string tag, input logic [2:0] f,
                            input logic a, input logic b);
    exp_t e;
    e.tag = tag; e.f = f; e.a = a; e.b = b;
    q.push_back(e);
  endtask

  // monitor: pops expected items mid-cycle
  always begin
    @(posedge clk_i);
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (flags_o !== e.f || intra_no !== e.a || intrb_no !== e.b) begin
        n_bad++;
        $display("FAIL %s: flags=%b a=%b b=%b expected flags=%b a=%b b=%b",
                 e.tag, flags_o, intra_no, intrb_no, e.f, e.a, e.b);
      end
    end
  end

  initial begin
    #(100000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    alm_match_i = '0; tick32k_i = 0; per_tick_i = 0; wr_en_i = 0;
    wr_data_i = 3'b111; alm_en_i = en_q; level_mode_i = lvl_q;
    @(posedge clk_i); @(posedge clk_i); #1;
    expect_out("R1 reset", 3'b000, 1, 1);
    @(posedge clk_i); #1;
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 weekly delay
    step(2'b01, 1'b0, 1'b0, 1'b0, 3'b111);
    tick(); tick();
    expect_out("R2 early", 3'b000, 1, 1);
    tick();
    expect_out("R2 set/R7 pin b", 3'b001, 1, 0);

    // R4 write 1 no effect
    wr(3'b111);
    expect_out("R4 write1", 3'b001, 1, 0);
    // R4 clear weekly
    wr(3'b110);
    expect_out("R4 clear", 3'b000, 1, 1);
    // R5 stays released
    for (int i = 0; i < 5; i++) tick();
    expect_out("R5 released", 3'b000, 1, 1);

    // daily alarm, R7 pin a
    step(2'b10, 1'b0, 1'b0, 1'b0, 3'b111);
    tick(); tick(); tick();
    expect_out("R7 pin a daily", 3'b010, 0, 1);

    // R3 disable masks and discards
    en_q = 2'b01; idle();
    expect_out("R3 masked", 3'b000, 1, 1);
    en_q = 2'b11; idle();
    expect_out("R3 discarded", 3'b000, 1, 1);
    en_q = 2'b01;
    step(2'b10, 1'b0, 1'b0, 1'b0, 3'b111);
    tick(); tick(); tick();
    en_q = 2'b11;
    tick(); tick(); tick();
    expect_out("R3 match ignored", 3'b000, 1, 1);

    // R6 collision: clear write with match
    step(2'b01, 1'b0, 1'b0, 1'b1, 3'b110);
    tick(); tick(); tick(); tick();
    expect_out("R6 collision", 3'b000, 1, 1);

    // R8 level mode periodic
    step(2'b00, 1'b0, 1'b1, 1'b0, 3'b111);
    expect_out("R8 set", 3'b100, 0, 1);
    tick(); tick();
    expect_out("R8 held", 3'b100, 0, 1);
    wr(3'b111);
    expect_out("R4 write1 per", 3'b100, 0, 1);

    // R7 OR of daily and periodic
    step(2'b10, 1'b0, 1'b0, 1'b0, 3'b111);
    tick(); tick(); tick();
    expect_out("R7 both", 3'b110, 0, 1);
    wr(3'b101);
    expect_out("R7 per only", 3'b100, 0, 1);
    wr(3'b011);
    expect_out("R8 clear", 3'b000, 1, 1);

    // R9 pulse mode
    lvl_q = 1'b0;
    step(2'b00, 1'b0, 1'b1, 1'b0, 3'b111);
    expect_out("R9 set", 3'b100, 0, 1);
    wr(3'b011);
    expect_out("R9 write ignored", 3'b100, 0, 1);
    tick();
    expect_out("R9 self clear", 3'b000, 1, 1);

    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule